// File: doc/BRIEF.md
# Dual-Port ATM Cell Bus PHY Interface

This block sits on the physical-layer side of a byte-wide ATM cell bus and serves two internal cell channels: port 0 carries the fast (low-latency) flow and port 1 carries the interleaved flow. Each port has one cell buffer in each direction, sized for a parameter number of 53-byte cells (eight by default). The ATM layer device drives the bus clock, the addresses and the active-low enables. The block answers polls on a shared cell-available line for each direction. It accepts a port selection and moves whole cells one byte per clock. One clock domain covers the bus and the internal channel sides.

In multi-port mode each port responds to its own programmable 5-bit bus address. In single-port mode the address lines are ignored and one configured channel is served. The internal channels use plain valid/ready byte streams. A channel pushes cell bytes into its receive buffer, and those bytes are offered to the ATM device once a whole cell has arrived. Bytes that the ATM device sends are released to the channel only after the complete cell has been accepted. A configuration bit forces every bus output enable low so the pads float.

Top module: `cellbus_dual_phy`

## Requirements
- R1: In multi-port mode, a clav output is updated one clock after the address is on the bus. It is 1 when the addressed port can serve a cell: on receive it holds at least one complete cell, and on transmit it has at least 53 bytes of free space. An address that matches no configured port gives 0.
- R2: Address 5'h1F never matches a port. Polling it gives clav 0. Selecting it moves no byte and consumes nothing from any buffer.
- R3: The address sampled on the last clock with enable high (while no cell is in progress) selects the port. The selected port stays locked until all 53 bytes of its cell have moved, even across enable pauses.
- R4: On receive, each clock edge that samples rx enable low (with a port selected and a cell available or in progress) puts one byte on ut_rx_data after that edge. The 53 bytes of a cell come out in the order they were written. ut_rx_soc is 1 only alongside the first byte.
- R5: While a port has a cell in progress, polling that port gives clav 1 for the whole transfer.
- R6: Each buffer holds BUF_CELLS cells. Transmit clav for a port drops to 0 when its free space is under 53 bytes. Receive clav stays 0 until all 53 bytes of a cell are buffered.
- R7: Transmit data and SOC are taken only on edges where tx enable is low. A byte presented while enable is high is ignored.
- R8: A transmit cell is discarded, and the sticky flag ut_tx_err is set until reset, in three cases: SOC is missing on its first byte, SOC appears on a later byte, or SOC arrives when the port lacks room for a full cell. A discarded cell never reaches the channel.
- R9: In single-port mode (cfg_level2 = 0), bus addresses are ignored and only the channel named by cfg_single_ch (0 fast, 1 interleaved) is polled, selected and transferred.
- R10: cfg_float = 1 forces ut_clav_oe and ut_rx_oe low. Otherwise ut_clav_oe is 1, and ut_rx_oe is 1 only on the clock after an edge that sampled rx enable low.
- R11: chin_ready is 1 while the receive buffer has space. chout_valid is 1 only while whole accepted cells remain unread, so it stays 0 during an incoming cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock from the ATM layer device |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level2 | input | 1 | 1 = multi-port addressed mode, 0 = single-port mode |
| cfg_single_ch | input | 1 | Channel served in single-port mode (0 fast, 1 interleaved) |
| cfg_port_addr | input | 2x5 | Bus address of each port |
| cfg_float | input | 1 | Force all bus output enables low |
| ut_rx_addr | input | 5 | Receive-side poll/select address |
| ut_rx_enb_n | input | 1 | Receive enable, active low |
| ut_rx_clav | output | 1 | Receive cell available |
| ut_rx_soc | output | 1 | Receive start of cell |
| ut_rx_data | output | 8 | Receive data byte |
| ut_rx_oe | output | 1 | Output enable for ut_rx_data and ut_rx_soc |
| ut_tx_addr | input | 5 | Transmit-side poll/select address |
| ut_tx_enb_n | input | 1 | Transmit enable, active low |
| ut_tx_soc | input | 1 | Transmit start of cell |
| ut_tx_data | input | 8 | Transmit data byte |
| ut_tx_clav | output | 1 | Transmit cell space available |
| ut_clav_oe | output | 1 | Output enable for both clav lines |
| ut_tx_err | output | 1 | Sticky discarded-cell flag |
| chin_valid | input | 2 | Channel byte valid, toward the ATM receive side |
| chin_data | input | 2x8 | Channel byte, toward the ATM receive side |
| chin_ready | output | 2 | Receive buffer can take a byte |
| chout_valid | output | 2 | Accepted transmit byte ready for the channel |
| chout_data | output | 2x8 | Accepted transmit byte |
| chout_ready | input | 2 | Channel takes the byte |

## Verification
The bench goes after the cell boundaries. It holds back the 53rd byte of a receive cell, which exposes a design that announces a partial cell. It keeps polling a port that is mid-transfer, where a design that recomputes clav from buffer level alone would drop the line after the first byte. It selects the null address with enable low, which catches a design that pops data for an unmatched selection. Transmit cells are sent with a stray SOC, with no SOC, and into a buffer holding exactly seven and then eight cells. A design with a wrong rollback, a wrong space threshold or an overflow would leak bytes to the channel or corrupt the cells that follow. Single-port mode is driven with the null address to show that addresses stop mattering there.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   localparam int unsigned CELL_LEN      = 53;
   localparam int unsigned DEF_DW        = 8;
   localparam int unsigned DEF_AW        = 5;
   localparam int unsigned DEF_BUF_CELLS = 8;
   localparam int unsigned DEF_PORTS     = 2;
endpackage

// File: rtl/cbp_cell_fifo.sv
module cbp_cell_fifo #(
   parameter  int unsigned DW        = 8,
   parameter  int unsigned CELL_LEN  = 53,
   parameter  int unsigned BUF_CELLS = 8,
   localparam int unsigned DEPTH     = CELL_LEN * BUF_CELLS,
   localparam int unsigned PW        = $clog2(DEPTH),
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_last,
   input  logic          wr_drop,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] avail,
   output logic [CW-1:0] free
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, back_ptr;
   logic [CW-1:0] used, pend;
   logic          wr_ok;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign wr_ok = wr_en && !wr_drop;
   // pointer just past the last committed byte
   always_comb begin
      if (int'(wr_ptr) >= int'(pend)) back_ptr = PW'(int'(wr_ptr) - int'(pend));
      else                            back_ptr = PW'(int'(wr_ptr) + int'(DEPTH) - int'(pend));
   end

   always_ff @(posedge clk) if (wr_ok) mem[wr_ptr] <= wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         used   <= '0;
         pend   <= '0;
      end else begin
         if (wr_drop)    wr_ptr <= back_ptr;
         else if (wr_ok) wr_ptr <= step(wr_ptr);
         if (rd_en)      rd_ptr <= step(rd_ptr);
         used <= used + CW'(wr_ok) - CW'(rd_en) - (wr_drop ? pend : '0);
         if (wr_drop)    pend <= '0;
         else if (wr_ok) pend <= wr_last ? '0 : pend + 1'b1;
      end
   end

   assign rd_data = mem[rd_ptr];
   assign avail   = used - pend;
   assign free    = CW'(DEPTH) - used;

   // R6
   fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> used < CW'(DEPTH));
   // R11
   fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> avail != '0);
endmodule

// File: rtl/cbp_addr_match.sv
module cbp_addr_match #(
   parameter  int unsigned NPORT = 2,
   parameter  int unsigned AW    = 5,
   localparam int unsigned SW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                       level2,
   input  logic [SW-1:0]              single_ch,
   input  logic [NPORT-1:0][AW-1:0]   port_addr,
   input  logic [AW-1:0]              bus_addr,
   output logic [NPORT-1:0]           hit,
   output logic [SW-1:0]              first
);
   localparam logic [AW-1:0] NULL_ADDR = '1;

   for (genvar i = 0; i < NPORT; i++) begin : g_hit
      assign hit[i] = level2 ? (bus_addr != NULL_ADDR && bus_addr == port_addr[i])
                             : (single_ch == SW'(i));
   end

   // lowest matching port wins if two ports share an address
   always_comb begin
      first = '0;
      for (int i = NPORT - 1; i >= 0; i--) if (hit[i]) first = SW'(i);
   end
endmodule

// File: rtl/cbp_rx_side.sv
module cbp_rx_side #(
   parameter  int unsigned NPORT    = 2,
   parameter  int unsigned DW       = 8,
   parameter  int unsigned CELL_LEN = 53,
   parameter  int unsigned CW       = 9,
   localparam int unsigned SW       = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int unsigned OW       = $clog2(CELL_LEN)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enb_n,
   input  logic [NPORT-1:0]            hit,
   input  logic [SW-1:0]               first,
   input  logic [NPORT-1:0][CW-1:0]    avail,
   input  logic [NPORT-1:0][DW-1:0]    rd_data,
   output logic [NPORT-1:0]            rd_en,
   output logic                        clav,
   output logic                        soc,
   output logic [DW-1:0]               data,
   output logic                        drive
);
   localparam logic [OW-1:0] LAST = OW'(CELL_LEN - 1);

   logic [OW-1:0]    off_q;
   logic [SW-1:0]    sel_q;
   logic             sel_vld, go;
   logic [NPORT-1:0] serve;

   for (genvar i = 0; i < NPORT; i++) begin : g_serve
      assign serve[i] = (avail[i] >= CW'(CELL_LEN)) ||
                        (sel_vld && sel_q == SW'(i) && off_q != '0);
      assign rd_en[i] = go && sel_q == SW'(i);
   end

   assign go = !enb_n && sel_vld && (off_q != '0 || serve[sel_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         sel_q   <= '0;
         sel_vld <= 1'b0;
         clav    <= 1'b0;
         soc     <= 1'b0;
         data    <= '0;
         drive   <= 1'b0;
      end else begin
         clav  <= |(hit & serve);
         drive <= !enb_n;
         soc   <= go && off_q == '0;
         if (go) begin
            data  <= rd_data[sel_q];
            off_q <= (off_q == LAST) ? '0 : off_q + 1'b1;
         end
         if (enb_n && off_q == '0) begin
            sel_vld <= |hit;
            sel_q   <= first;
         end
      end
   end

   // R4
   rx_soc_after_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soc |-> $past(!enb_n));
   // R3
   rx_sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_q != '0 |=> sel_q == $past(sel_q));
endmodule

// File: rtl/cbp_tx_side.sv
module cbp_tx_side #(
   parameter  int unsigned NPORT    = 2,
   parameter  int unsigned CELL_LEN = 53,
   parameter  int unsigned CW       = 9,
   localparam int unsigned SW       = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int unsigned OW       = $clog2(CELL_LEN)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enb_n,
   input  logic                        soc_in,
   input  logic [NPORT-1:0]            hit,
   input  logic [SW-1:0]               first,
   input  logic [NPORT-1:0][CW-1:0]    free,
   output logic [NPORT-1:0]            wr_en,
   output logic [NPORT-1:0]            wr_drop,
   output logic                        wr_last,
   output logic                        clav,
   output logic                        err
);
   localparam logic [OW-1:0] LAST = OW'(CELL_LEN - 1);

   logic [OW-1:0]    off_q;
   logic [SW-1:0]    sel_q;
   logic             sel_vld, take, start_ok, keep, bad;
   logic [NPORT-1:0] room, serve;

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      assign room[i]    = free[i] >= CW'(CELL_LEN);
      assign serve[i]   = room[i] || (sel_vld && sel_q == SW'(i) && off_q != '0);
      assign wr_en[i]   = sel_q == SW'(i) && (start_ok || keep);
      assign wr_drop[i] = sel_q == SW'(i) && take && off_q != '0 && soc_in;
   end

   assign take     = !enb_n && sel_vld;
   assign start_ok = take && off_q == '0 && soc_in && room[sel_q];
   assign keep     = take && off_q != '0 && !soc_in;
   assign bad      = take && !start_ok && !keep;
   assign wr_last  = off_q == LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         sel_q   <= '0;
         sel_vld <= 1'b0;
         clav    <= 1'b0;
         err     <= 1'b0;
      end else begin
         clav <= |(hit & serve);
         if (bad) err <= 1'b1;
         if (start_ok || keep) off_q <= wr_last ? '0 : off_q + 1'b1;
         else if (bad)         off_q <= '0;
         if (enb_n && off_q == '0) begin
            sel_vld <= |hit;
            sel_q   <= first;
         end
      end
   end

   // R8
   tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   // R3
   tx_sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_q != '0 |=> sel_q == $past(sel_q));
endmodule

// File: rtl/cellbus_dual_phy.sv
module cellbus_dual_phy
   import cbp_pkg::*;
#(
   parameter  int unsigned NPORT     = DEF_PORTS,
   parameter  int unsigned DW        = DEF_DW,
   parameter  int unsigned AW        = DEF_AW,
   parameter  int unsigned BUF_CELLS = DEF_BUF_CELLS,
   parameter  int unsigned CELL_BYTES = CELL_LEN,
   localparam int unsigned SW        = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int unsigned CW        = $clog2(CELL_BYTES * BUF_CELLS + 1),
   localparam int unsigned OW        = $clog2(CELL_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_level2,
   input  logic [SW-1:0]              cfg_single_ch,
   input  logic [NPORT-1:0][AW-1:0]   cfg_port_addr,
   input  logic                       cfg_float,
   input  logic [AW-1:0]              ut_rx_addr,
   input  logic                       ut_rx_enb_n,
   output logic                       ut_rx_clav,
   output logic                       ut_rx_soc,
   output logic [DW-1:0]              ut_rx_data,
   output logic                       ut_rx_oe,
   input  logic [AW-1:0]              ut_tx_addr,
   input  logic                       ut_tx_enb_n,
   input  logic                       ut_tx_soc,
   input  logic [DW-1:0]              ut_tx_data,
   output logic                       ut_tx_clav,
   output logic                       ut_clav_oe,
   output logic                       ut_tx_err,
   input  logic [NPORT-1:0]           chin_valid,
   input  logic [NPORT-1:0][DW-1:0]   chin_data,
   output logic [NPORT-1:0]           chin_ready,
   output logic [NPORT-1:0]           chout_valid,
   output logic [NPORT-1:0][DW-1:0]   chout_data,
   input  logic [NPORT-1:0]           chout_ready
);
   localparam logic [OW-1:0] LAST = OW'(CELL_BYTES - 1);

   initial begin
      if (NPORT < 1 || NPORT > (1 << AW) - 1 || CELL_BYTES < 2 || BUF_CELLS < 1 || DW < 1)
         $error("cellbus_dual_phy: unsupported parameter set");
   end

   logic [NPORT-1:0]          rx_hit, tx_hit, rx_rd, tx_wr, tx_drop;
   logic [SW-1:0]             rx_first, tx_first;
   logic [NPORT-1:0][CW-1:0]  rx_avail, rx_free, tx_avail, tx_free;
   logic [NPORT-1:0][DW-1:0]  rx_rd_data;
   logic                      tx_last, rx_drive;

   cbp_addr_match #(.NPORT(NPORT), .AW(AW)) i_rx_match (
      .level2(cfg_level2), .single_ch(cfg_single_ch), .port_addr(cfg_port_addr),
      .bus_addr(ut_rx_addr), .hit(rx_hit), .first(rx_first));
   cbp_addr_match #(.NPORT(NPORT), .AW(AW)) i_tx_match (
      .level2(cfg_level2), .single_ch(cfg_single_ch), .port_addr(cfg_port_addr),
      .bus_addr(ut_tx_addr), .hit(tx_hit), .first(tx_first));

   cbp_rx_side #(.NPORT(NPORT), .DW(DW), .CELL_LEN(CELL_BYTES), .CW(CW)) i_rx (
      .clk(clk), .rst_n(rst_n), .enb_n(ut_rx_enb_n), .hit(rx_hit), .first(rx_first),
      .avail(rx_avail), .rd_data(rx_rd_data), .rd_en(rx_rd), .clav(ut_rx_clav),
      .soc(ut_rx_soc), .data(ut_rx_data), .drive(rx_drive));

   cbp_tx_side #(.NPORT(NPORT), .CELL_LEN(CELL_BYTES), .CW(CW)) i_tx (
      .clk(clk), .rst_n(rst_n), .enb_n(ut_tx_enb_n), .soc_in(ut_tx_soc), .hit(tx_hit),
      .first(tx_first), .free(tx_free), .wr_en(tx_wr), .wr_drop(tx_drop),
      .wr_last(tx_last), .clav(ut_tx_clav), .err(ut_tx_err));

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [OW-1:0] in_off_q;
      logic          in_wr;

      assign chin_ready[p]  = rx_free[p] != '0;
      assign in_wr          = chin_valid[p] && chin_ready[p];
      assign chout_valid[p] = tx_avail[p] != '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     in_off_q <= '0;
         else if (in_wr) in_off_q <= (in_off_q == LAST) ? '0 : in_off_q + 1'b1;
      end

      cbp_cell_fifo #(.DW(DW), .CELL_LEN(CELL_BYTES), .BUF_CELLS(BUF_CELLS)) i_rx_buf (
         .clk(clk), .rst_n(rst_n), .wr_en(in_wr), .wr_data(chin_data[p]),
         .wr_last(in_off_q == LAST), .wr_drop(1'b0), .rd_en(rx_rd[p]),
         .rd_data(rx_rd_data[p]), .avail(rx_avail[p]), .free(rx_free[p]));

      cbp_cell_fifo #(.DW(DW), .CELL_LEN(CELL_BYTES), .BUF_CELLS(BUF_CELLS)) i_tx_buf (
         .clk(clk), .rst_n(rst_n), .wr_en(tx_wr[p]), .wr_data(ut_tx_data),
         .wr_last(tx_last), .wr_drop(tx_drop[p]),
         .rd_en(chout_valid[p] && chout_ready[p]), .rd_data(chout_data[p]),
         .avail(tx_avail[p]), .free(tx_free[p]));
   end

   assign ut_clav_oe = !cfg_float;
   assign ut_rx_oe   = !cfg_float && rx_drive;
endmodule

// File: tb/test_cellbus_dual_phy.sv
module test_cellbus_dual_phy;
   localparam logic [4:0] A_FAST = 5'h03, A_INTL = 5'h0A, A_NULL = 5'h1F, A_NONE = 5'h09;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_level2 = 1'b1, cfg_single_ch = 1'b0, cfg_float = 1'b0;
   logic [1:0][4:0] cfg_port_addr;
   logic [4:0] ut_rx_addr = A_NULL, ut_tx_addr = A_NULL;
   logic ut_rx_enb_n = 1'b1, ut_tx_enb_n = 1'b1, ut_tx_soc = 1'b0;
   logic [7:0] ut_tx_data = '0;
   logic ut_rx_clav, ut_rx_soc, ut_rx_oe, ut_tx_clav, ut_clav_oe, ut_tx_err;
   logic [7:0] ut_rx_data;
   logic [1:0] chin_valid = '0, chin_ready, chout_valid, chout_ready = '0;
   logic [1:0][7:0] chin_data, chout_data;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   assign cfg_port_addr[0] = A_FAST;
   assign cfg_port_addr[1] = A_INTL;

   always #10 clk = ~clk;

   cellbus_dual_phy i_cellbus_dual_phy (
      .clk(clk), .rst_n(rst_n), .cfg_level2(cfg_level2), .cfg_single_ch(cfg_single_ch),
      .cfg_port_addr(cfg_port_addr), .cfg_float(cfg_float),
      .ut_rx_addr(ut_rx_addr), .ut_rx_enb_n(ut_rx_enb_n), .ut_rx_clav(ut_rx_clav),
      .ut_rx_soc(ut_rx_soc), .ut_rx_data(ut_rx_data), .ut_rx_oe(ut_rx_oe),
      .ut_tx_addr(ut_tx_addr), .ut_tx_enb_n(ut_tx_enb_n), .ut_tx_soc(ut_tx_soc),
      .ut_tx_data(ut_tx_data), .ut_tx_clav(ut_tx_clav), .ut_clav_oe(ut_clav_oe),
      .ut_tx_err(ut_tx_err), .chin_valid(chin_valid), .chin_data(chin_data),
      .chin_ready(chin_ready), .chout_valid(chout_valid), .chout_data(chout_data),
      .chout_ready(chout_ready));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_bytes(input int p, input logic [7:0] seed, input int from, input int n);
      for (int k = from; k < from + n; k++) begin
         @(negedge clk);
         chin_valid[p] = 1'b1;
         chin_data[p]  = 8'(seed + k);
      end
      @(negedge clk);
      chin_valid[p] = 1'b0;
   endtask

   task automatic poll_rx(input logic [4:0] a, output logic c);
      @(negedge clk); ut_rx_addr = a;
      @(negedge clk); c = ut_rx_clav;
   endtask

   task automatic poll_tx(input logic [4:0] a, output logic c);
      @(negedge clk); ut_tx_addr = a;
      @(negedge clk); c = ut_tx_clav;
   endtask

   task automatic rx_cell(input logic [4:0] a, input logic [7:0] seed);
      @(negedge clk); ut_rx_addr = a; ut_rx_enb_n = 1'b1;
      @(negedge clk); ut_rx_enb_n = 1'b0;
      for (int k = 0; k < 53; k++) begin
         @(negedge clk);
         chk("R4 rx data", ut_rx_data, 8'(seed + k));
         chk("R4 rx soc", ut_rx_soc, k == 0);
         chk("R5 clav held", ut_rx_clav, 1);
         if (k == 20) chk("R10 rx oe during cell", ut_rx_oe, 1);
      end
      ut_rx_enb_n = 1'b1;
      @(negedge clk);
      chk("R10 rx oe idle", ut_rx_oe, 0);
   endtask

   task automatic tx_cell(input logic [4:0] a, input int p, input logic [7:0] seed,
                          input int soc_at, input bit no_soc, input bit watch);
      @(negedge clk); ut_tx_addr = a; ut_tx_enb_n = 1'b1; ut_tx_soc = 1'b1; ut_tx_data = 8'hEE;
      for (int k = 0; k < 53; k++) begin
         @(negedge clk);
         ut_tx_enb_n = 1'b0;
         ut_tx_data  = 8'(seed + k);
         ut_tx_soc   = ((k == 0) && !no_soc) || (k == soc_at);
         if (watch && k == 26) chk("R11 no output mid cell", chout_valid[p], 0);
      end
      @(negedge clk); ut_tx_enb_n = 1'b1; ut_tx_soc = 1'b0;
   endtask

   task automatic drain(input int p, input logic [7:0] seed, input string tag);
      for (int k = 0; k < 53; k++) begin
         @(negedge clk);
         chk(tag, chout_valid[p], 1);
         chk(tag, chout_data[p], 8'(seed + k));
         chout_ready[p] = 1'b1;
      end
      @(negedge clk); chout_ready[p] = 1'b0;
   endtask

   task automatic test_reset();
      chk("R11 reset chin_ready", chin_ready, 2'b11);
      chk("R11 reset chout_valid", chout_valid, 2'b00);
      chk("R1 reset clav", {ut_rx_clav, ut_tx_clav}, 0);
      chk("R8 reset err", ut_tx_err, 0);
      chk("R10 reset oe", {ut_clav_oe, ut_rx_oe}, 2'b10);
   endtask

   task automatic test_poll_tx();
      logic c;
      poll_tx(A_FAST, c); chk("R1 tx poll fast", c, 1);
      poll_tx(A_NULL, c); chk("R2 tx poll null", c, 0);
      poll_tx(A_NONE, c); chk("R1 tx poll unassigned", c, 0);
      poll_tx(A_INTL, c); chk("R1 tx poll intl", c, 1);
   endtask

   task automatic test_rx_path();
      logic c;
      push_bytes(0, 8'h10, 0, 52);
      poll_rx(A_FAST, c); chk("R6 partial cell not offered", c, 0);
      push_bytes(0, 8'h10, 52, 1);
      poll_rx(A_FAST, c); chk("R1 rx poll full cell", c, 1);
      poll_rx(A_INTL, c); chk("R1 rx poll empty port", c, 0);
      rx_cell(A_FAST, 8'h10);
      poll_rx(A_FAST, c); chk("R1 rx poll after read", c, 0);
   endtask

   task automatic test_null_addr();
      logic c;
      push_bytes(1, 8'h60, 0, 53);
      poll_rx(A_NULL, c); chk("R2 rx poll null", c, 0);
      @(negedge clk); ut_rx_addr = A_NULL;
      @(negedge clk); ut_rx_enb_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); chk("R2 null select no soc", ut_rx_soc, 0);
      end
      ut_rx_enb_n = 1'b1;
      poll_rx(A_INTL, c); chk("R2 cell still held", c, 1);
      rx_cell(A_INTL, 8'h60);
   endtask

   task automatic test_tx_path();
      tx_cell(A_INTL, 1, 8'hA0, -1, 1'b0, 1'b1);
      @(negedge clk);
      chk("R7 fast untouched", chout_valid[0], 0);
      drain(1, 8'hA0, "R7 tx cell to channel");
      chk("R11 empty after drain", chout_valid[1], 0);
      chk("R8 no error on good cells", ut_tx_err, 0);
   endtask

   task automatic test_bad_soc();
      tx_cell(A_FAST, 0, 8'h20, 10, 1'b0, 1'b0);
      @(negedge clk);
      chk("R8 stray soc sets err", ut_tx_err, 1);
      chk("R8 stray soc cell dropped", chout_valid[0], 0);
      tx_cell(A_FAST, 0, 8'h30, -1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R8 missing soc cell dropped", chout_valid[0], 0);
      tx_cell(A_FAST, 0, 8'h40, -1, 1'b0, 1'b0);
      drain(0, 8'h40, "R8 good cell after discard");
      chk("R8 err sticky", ut_tx_err, 1);
   endtask

   task automatic test_full();
      logic c;
      for (int n = 0; n < 8; n++) begin
         tx_cell(A_FAST, 0, 8'(n * 8), -1, 1'b0, 1'b0);
         if (n == 6) begin poll_tx(A_FAST, c); chk("R6 clav with one cell free", c, 1); end
      end
      poll_tx(A_FAST, c); chk("R6 clav when full", c, 0);
      tx_cell(A_FAST, 0, 8'h99, -1, 1'b0, 1'b0);
      drain(0, 8'h00, "R6 first buffered cell");
      poll_tx(A_FAST, c); chk("R6 clav after drain", c, 1);
      for (int n = 1; n < 8; n++) drain(0, 8'(n * 8), "R6 buffered cells in order");
      @(negedge clk);
      chk("R8 overflow cell dropped", chout_valid[0], 0);
   endtask

   task automatic test_single();
      logic c;
      @(negedge clk); cfg_level2 = 1'b0; cfg_single_ch = 1'b1;
      poll_tx(A_NULL, c); chk("R9 single mode ignores address", c, 1);
      tx_cell(A_NULL, 1, 8'hC0, -1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R9 fast unused in single mode", chout_valid[0], 0);
      drain(1, 8'hC0, "R9 single mode tx");
      push_bytes(0, 8'h70, 0, 53);
      poll_rx(A_FAST, c); chk("R9 other channel not served", c, 0);
      push_bytes(1, 8'h80, 0, 53);
      poll_rx(A_NULL, c); chk("R9 served channel polled", c, 1);
      rx_cell(A_NULL, 8'h80);
   endtask

   task automatic test_float();
      @(negedge clk); cfg_float = 1'b1; ut_rx_enb_n = 1'b0;
      @(negedge clk);
      chk("R10 float clav oe", ut_clav_oe, 0);
      chk("R10 float rx oe", ut_rx_oe, 0);
      cfg_float = 1'b0;
      @(negedge clk);
      chk("R10 release rx oe", ut_rx_oe, 1);
      chk("R10 release clav oe", ut_clav_oe, 1);
      ut_rx_enb_n = 1'b1;
   endtask

   initial begin
      chin_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_poll_tx();
      test_rx_path();
      test_null_addr();
      test_tx_path();
      test_bad_soc();
      test_full();
      test_single();
      test_float();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule